// File: doc/BRIEF.md
# Mixed-Speed Bus Access Window Timer

This block decides how long each processor memory access lasts on a system that runs a master clock of nominally 14 MHz. Each request carries a bank number and a flag that marks a ROM fetch. The block sorts the request into one of three classes and answers with a one-cycle done strobe once the access window has elapsed. The three classes are ROM, fast RAM, and the two slow banks 0xE0 and 0xE1.

Fast RAM and ROM take a short window of fixed length. Slow-bank reads and writes go through a slower bus. That bus has a free-running window clock, and each window lasts a set number of master cycles. A window counter that runs modulo 64 lengthens one window in every 64, so that video timing stays locked to the colour subcarrier. A slow request waits for the next window boundary and then takes up that whole window. The block reports the current slow-window phase, and whether the current window is a long one.

Only one access is in flight at a time. Address decoding and the memory arrays lie outside this block.

Top module: `bus_window_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, ready is 1, done is 0, slow_phase is 0 and slow_long is 1. The window counter starts at zero, so the first slow window is a long one.
- R2: slow_phase rises by one in every master cycle and wraps to 0 after the last cycle of a window. A normal window covers phases 0 to 13, which is 14 cycles.
- R3: The window counter advances once per window, modulo 64. When it is zero, the window covers phases 0 to 15, which is 16 cycles, and slow_long is 1 for the whole window. The other 63 windows are normal length.
- R4: A request with req_rom=1 is a ROM access, whatever its bank, including 0xE0 and 0xE1. If it is accepted at clock edge k, done is high for one cycle after edge k+5.
- R5: A request with req_rom=0 and a bank other than 0xE0 or 0xE1 is a fast-RAM access. It has the same five-cycle timing as R4.
- R6: A request with req_rom=0 and bank 0xE0 or 0xE1 is a slow access. It waits for the first slow window that begins at or after its acceptance edge. done is then high in the cycle after that window's last cycle. A request accepted on the last cycle of a window uses the window that starts at that edge.
- R7: A request is accepted at a clock edge where both ready and req_valid are 1. ready drops at that edge and stays low while done pulses. ready returns in the cycle after done, and done is never high for two cycles in a row.
- R8: A request presented while ready is 0 is ignored. It does not change the timing of the access in flight, and it is not queued.
- R9: The slow window clock keeps running whether or not accesses occur. Neither accepting a request nor finishing one changes the phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_rom | input | 1 | Request is a ROM fetch |
| req_bank | input | 8 | Bank number of the request |
| ready | output | 1 | Block is idle and will accept a request |
| done | output | 1 | One-cycle strobe at the end of the access window |
| slow_phase | output | 4 | Master-cycle position inside the current slow window |
| slow_long | output | 1 | Current slow window is the stretched one |

## Verification
The assertions assume that reset is held for at least two clock edges. They also assume that req_valid, req_rom and req_bank change only away from the rising edge. They place no limit on when a request appears: a request raised during a busy access is allowed and must be dropped. The stimulus drives requests at random, including during busy periods, so the ignore path is exercised often. Bank values are biased toward the two slow banks, and ROM fetches are issued to those same banks. Directed slow requests land on the last cycle of a window and on its first cycle, and the run is long enough to pass several stretched windows.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  typedef enum logic [1:0] {
    KIND_FAST = 2'd0,
    KIND_ROM  = 2'd1,
    KIND_SLOW = 2'd2
  } acc_kind_t;

  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_FAST = 3'd1,
    SEQ_WAIT = 3'd2,
    SEQ_RUN  = 3'd3,
    SEQ_DONE = 3'd4
  } seq_state_t;

endpackage

// File: rtl/bwt_classify.sv
module bwt_classify
  import bwt_pkg::*;
#(
  parameter int          BANK_W      = 8,
  parameter logic [7:0]  SLOW_BANK_A = 8'hE0,
  parameter logic [7:0]  SLOW_BANK_B = 8'hE1
) (
  input  logic              is_rom,
  input  logic [BANK_W-1:0] bank,
  output acc_kind_t         kind
);

  logic in_slow;

  assign in_slow = (bank == BANK_W'(SLOW_BANK_A)) || (bank == BANK_W'(SLOW_BANK_B));

  always_comb begin
    if (is_rom)       kind = KIND_ROM;
    else if (in_slow) kind = KIND_SLOW;
    else              kind = KIND_FAST;
  end

endmodule

// File: rtl/bwt_slow_clock.sv
module bwt_slow_clock #(
  parameter int SLOW_CYCLES   = 14,
  parameter int LONG_CYCLES   = 16,
  parameter int STRETCH_EVERY = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  output logic [$clog2(LONG_CYCLES)-1:0] phase,
  output logic                           long_win,
  output logic                           win_end
);

  localparam int PH_W  = $clog2(LONG_CYCLES);
  localparam int WIN_W = (STRETCH_EVERY > 1) ? $clog2(STRETCH_EVERY) : 1;

  logic [PH_W-1:0]  ph_q;
  logic [WIN_W-1:0] win_q;
  logic [PH_W-1:0]  last_ph;

  assign long_win = (win_q == '0);
  assign last_ph  = long_win ? PH_W'(LONG_CYCLES - 1) : PH_W'(SLOW_CYCLES - 1);
  assign win_end  = (ph_q == last_ph);
  assign phase    = ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      win_q <= '0;
    end else if (win_end) begin
      ph_q  <= '0;
      win_q <= (win_q == WIN_W'(STRETCH_EVERY - 1)) ? '0 : win_q + 1'b1;
    end else begin
      ph_q  <= ph_q + 1'b1;
    end
  end

endmodule

// File: rtl/bwt_access_seq.sv
module bwt_access_seq
  import bwt_pkg::*;
#(
  parameter int FAST_CYCLES = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      req_valid,
  input  acc_kind_t kind,
  input  logic      win_end,
  output logic      ready,
  output logic      done
);

  localparam int CNT_W = (FAST_CYCLES > 1) ? $clog2(FAST_CYCLES) : 1;

  seq_state_t       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ready_q, done_q;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          if (kind == KIND_SLOW) begin
            st_n = win_end ? SEQ_RUN : SEQ_WAIT;
          end else begin
            st_n  = SEQ_FAST;
            cnt_n = CNT_W'(FAST_CYCLES - 1);
          end
        end
      end
      SEQ_FAST: begin
        if (cnt_q == '0) st_n = SEQ_DONE;
        else             cnt_n = cnt_q - 1'b1;
      end
      SEQ_WAIT: if (win_end) st_n = SEQ_RUN;
      SEQ_RUN:  if (win_end) st_n = SEQ_DONE;
      SEQ_DONE: st_n = SEQ_IDLE;
      default:  st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SEQ_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      ready_q <= (st_n == SEQ_IDLE);
      done_q  <= (st_n == SEQ_DONE);
    end
  end

  assign ready = ready_q;
  assign done  = done_q;

endmodule

// File: rtl/bus_window_timer.sv
module bus_window_timer
  import bwt_pkg::*;
#(
  parameter int         BANK_W        = 8,
  parameter logic [7:0] SLOW_BANK_A   = 8'hE0,
  parameter logic [7:0] SLOW_BANK_B   = 8'hE1,
  parameter int         FAST_CYCLES   = 5,
  parameter int         SLOW_CYCLES   = 14,
  parameter int         LONG_CYCLES   = 16,
  parameter int         STRETCH_EVERY = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic                           req_rom,
  input  logic [BANK_W-1:0]              req_bank,
  output logic                           ready,
  output logic                           done,
  output logic [$clog2(LONG_CYCLES)-1:0] slow_phase,
  output logic                           slow_long
);

  acc_kind_t kind;
  logic      win_end;
  logic      accept;

  assign accept = req_valid & ready;

  bwt_classify #(
    .BANK_W(BANK_W), .SLOW_BANK_A(SLOW_BANK_A), .SLOW_BANK_B(SLOW_BANK_B)
  ) u_class (
    .is_rom(req_rom), .bank(req_bank), .kind(kind)
  );

  bwt_slow_clock #(
    .SLOW_CYCLES(SLOW_CYCLES), .LONG_CYCLES(LONG_CYCLES), .STRETCH_EVERY(STRETCH_EVERY)
  ) u_clock (
    .clk(clk), .rst(rst), .phase(slow_phase), .long_win(slow_long), .win_end(win_end)
  );

  bwt_access_seq #(
    .FAST_CYCLES(FAST_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(accept), .kind(kind), .win_end(win_end),
    .ready(ready), .done(done)
  );

endmodule

// File: rtl/bwt_checker.sv
module bwt_checker #(
  parameter int SLOW_CYCLES = 14,
  parameter int LONG_CYCLES = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           req_valid,
  input logic                           ready,
  input logic                           done,
  input logic [$clog2(LONG_CYCLES)-1:0] slow_phase,
  input logic                           slow_long
);

  assert_short_range_R2: assert property (@(posedge clk) disable iff (rst)
    !slow_long |-> (32'(slow_phase) < SLOW_CYCLES));

  assert_phase_step_R9: assert property (@(posedge clk) disable iff (rst)
    (slow_phase != '0) |-> (32'(slow_phase) == 32'($past(slow_phase)) + 1));

  assert_long_exit_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(slow_long) |-> (slow_phase == '0 && 32'($past(slow_phase)) == LONG_CYCLES - 1));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && ready));

  assert_not_both_R7: assert property (@(posedge clk) disable iff (rst)
    !(done && ready));

  assert_accept_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid) |=> !ready);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!ready && !done) |=> !ready);

endmodule

bind bus_window_timer bwt_checker #(
  .SLOW_CYCLES(SLOW_CYCLES), .LONG_CYCLES(LONG_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready), .done(done),
  .slow_phase(slow_phase), .slow_long(slow_long)
);

// File: tb/sim_bus_window_timer.sv
module sim_bus_window_timer;

  localparam int FAST = 5;
  localparam int SHORT = 14;
  localparam int LONGW = 16;
  localparam int EVERY = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_rom = 1'b0;
  logic [7:0] req_bank = 8'h00;
  logic       ready, done, slow_long;
  logic [3:0] slow_phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bus_window_timer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_rom(req_rom), .req_bank(req_bank),
    .ready(ready), .done(done), .slow_phase(slow_phase), .slow_long(slow_long)
  );

  // reference model: 0 idle, 1 fast/rom, 2 wait, 3 run, 4 done
  int m_ph, m_win, m_st, m_cnt, m_kind;

  function automatic int win_len(input int w);
    return (w == 0) ? LONGW : SHORT;
  endfunction

  function automatic int classify(input logic rom, input logic [7:0] bank);
    if (rom) return 1;
    if (bank == 8'hE0 || bank == 8'hE1) return 2;
    return 0;
  endfunction

  function automatic string kind_tag(input int k);
    if (k == 1) return "R4";
    if (k == 2) return "R6";
    return "R5";
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_ph <= 0; m_win <= 0; m_st <= 0; m_cnt <= 0;
    end else begin
      automatic bit endw = (m_ph == win_len(m_win) - 1);
      if (endw) begin
        m_ph  <= 0;
        m_win <= (m_win + 1) % EVERY;
      end else begin
        m_ph <= m_ph + 1;
      end
      case (m_st)
        0: if (req_valid) begin
             m_kind <= classify(req_rom, req_bank);
             if (classify(req_rom, req_bank) == 2) m_st <= endw ? 3 : 2;
             else begin m_st <= 1; m_cnt <= FAST - 1; end
           end
        1: if (m_cnt == 0) m_st <= 4; else m_cnt <= m_cnt - 1;
        2: if (endw) m_st <= 3;
        3: if (endw) m_st <= 4;
        default: m_st <= 0;
      endcase
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  logic prev_ignored = 1'b0;

  task automatic sample();
    string ptag;
    ptag = (m_st == 0) ? "R9" : ((m_win == 0) ? "R3" : "R2");
    chk(ptag, "slow_phase", int'(slow_phase), m_ph);
    chk("R3", "slow_long", int'(slow_long), (m_win == 0) ? 1 : 0);
    chk("R7", "ready", int'(ready), (m_st == 0) ? 1 : 0);
    chk(kind_tag(m_kind), "done", int'(done), (m_st == 4) ? 1 : 0);
    if (prev_ignored) chk("R8", "busy after ignored request", int'(ready | done),
                          (m_st == 0 || m_st == 4) ? 1 : 0);
    prev_ignored = req_valid && !ready;
  endtask

  task automatic step(input logic v, input logic rom, input logic [7:0] bank);
    @(negedge clk);
    sample();
    req_valid = v; req_rom = rom; req_bank = bank;
  endtask

  task automatic random_step();
    logic [7:0] b;
    int sel;
    sel = int'($urandom % 4);
    b = (sel == 0) ? 8'hE0 : (sel == 1) ? 8'hE1 : 8'($urandom);
    step(($urandom % 3) != 0, ($urandom % 4) == 0, b);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_kind = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "ready in reset", int'(ready), 1);
    chk("R1", "done in reset", int'(done), 0);
    chk("R1", "phase in reset", int'(slow_phase), 0);
    chk("R1", "long in reset", int'(slow_long), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "long after reset", int'(slow_long), 1);
    chk("R1", "ready after reset", int'(ready), 1);
    // R4: ROM fetch to a slow bank takes the short window
    step(1'b1, 1'b1, 8'hE0);
    repeat (8) step(1'b0, 1'b0, 8'h00);
    // R5: fast bank, with an ignored request during the access (R8)
    step(1'b1, 1'b0, 8'h12);
    repeat (2) step(1'b1, 1'b0, 8'hE1);
    repeat (8) step(1'b0, 1'b0, 8'h00);
    // R6: slow request on the last cycle of a window
    while (!(m_st == 0 && m_ph == win_len(m_win) - 1)) step(1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'hE1);
    repeat (20) step(1'b0, 1'b0, 8'h00);
    // R6: slow request on the first cycle of a window
    while (!(m_st == 0 && m_ph == 0)) step(1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'hE0);
    repeat (40) step(1'b0, 1'b0, 8'h00);
    // random traffic across several stretched windows
    for (int i = 0; i < 4000; i++) random_step();
    // R9: idle stretch covering a long window
    for (int i = 0; i < 1000; i++) step(1'b0, 1'b0, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule